// File: doc/BRIEF.md
# Debug Exception Gate and Level Router

This block sits beside a processor core's exception logic and decides, every clock, whether the core may take a debug exception in its present state. It also decides which privilege level receives that exception. It looks at the current privilege level (0 to 3), the security state, the hypervisor enable and its two trap-routing bits, the monitor's secure-debug-disable bit, the kernel debug enable, the debug mask flag, and the two lock status bits. From these it produces an enable flag and a target level.

The block also produces a syndrome flag that marks a same-level exception, the level at which a software breakpoint instruction is taken, and a single-step-active flag. Each output is registered once from the inputs sampled on the clock edge, so every result appears one cycle after its inputs. Address comparison, access trapping and exception entry are left to other blocks.

Top module: `dbg_gate_route`

## Requirements
- R1: The target level is 2 whenever `hyp_en` is 1 and at least one of `trap_all` or `trap_dbg` is 1.
- R2: If R1 does not apply, the target level is 3 when `mon_present` is 1, `lvl_wide[3]` is 0 and `is_secure` is 1. In every other case the target level is 1.
- R3: `dbg_en` is 0 whenever the current level is 3.
- R4: `dbg_en` is 0 when `is_secure` is 1, the current level is below 3 and `sec_dbg_off` is 1.
- R5: When the current level equals the target level, `dbg_en` is 1 only if `kern_dbg_en` is 1 and `dbg_mask` is 0.
- R6: When the current level differs from the target level, `dbg_en` is 1 only if the target level is higher than the current level.
- R7: When `os_lock` or `dbl_lock` is 1, `dbg_en` is 0, whatever the other inputs are.
- R8: `same_lvl` is 1 exactly when the target level equals the current level.
- R9: `brk_lvl` equals the target level, or the current level when the target level is lower than the current level.
- R10: `step_act` is 1 exactly when `step_bit` is 1, the bit of `lvl_wide` selected by the target level is 1, and `dbg_en` is 1.
- R11: Every output shows the result for the inputs sampled at the previous rising clock edge. While `rst_n` is 0 at a clock edge, all outputs clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_lvl | input | 2 | Current privilege level |
| is_secure | input | 1 | Core is in secure state |
| hyp_en | input | 1 | Hypervisor level is enabled |
| trap_all | input | 1 | Hypervisor traps general exceptions |
| trap_dbg | input | 1 | Hypervisor traps debug exceptions |
| mon_present | input | 1 | Level 3 is implemented |
| lvl_wide | input | 4 | Bit i is 1 when level i runs the 64-bit state |
| sec_dbg_off | input | 1 | Monitor disables debug from secure state |
| kern_dbg_en | input | 1 | Same-level debug enable |
| dbg_mask | input | 1 | Debug mask flag of the processor state |
| os_lock | input | 1 | OS lock status |
| dbl_lock | input | 1 | Double lock status |
| step_bit | input | 1 | Software single-step enable |
| dbg_en | output | 1 | Debug exceptions may be taken |
| tgt_lvl | output | 2 | Level that receives debug exceptions |
| same_lvl | output | 1 | Syndrome flag: target equals current level |
| brk_lvl | output | 2 | Level that takes a breakpoint instruction |
| step_act | output | 1 | Single-step is active |

## Verification
The hardest case to reach is a secure core at level 3 with a 32-bit monitor. There the target equals the current level, so the same-level rule would enable debug if the never-at-level-3 rule were missing. The stimulus therefore drives this state with the kernel enable set and the mask clear. A second case is level 2 with routing off. There the target (1) is below the current level, so the breakpoint level must rise to 2. Directed vectors cover each rule on its own, and a long run of random vectors covers the way the rules combine.

// File: rtl/dbg_route_pkg.sv
// Shared level type and fixed level codes for the debug gate/route block.
// Assumes four privilege levels encoded 0..3.
package dbg_route_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_KERN = lvl_t'(1);
    localparam lvl_t LVL_HYP  = lvl_t'(2);
    localparam lvl_t LVL_MON  = lvl_t'(3);
endpackage

// File: rtl/dbg_target_sel.sv
// Picks the privilege level that receives debug exceptions.
// Hypervisor routing wins, then a secure 32-bit monitor, else the kernel level.
// Purely combinational; assumes inputs are stable within the cycle.
module dbg_target_sel
    import dbg_route_pkg::*;
(
    input  logic hyp_en,
    input  logic trap_all,
    input  logic trap_dbg,
    input  logic mon_present,
    input  logic mon_wide,
    input  logic is_secure,
    output lvl_t tgt
);
    logic route_hyp;
    logic route_mon;

    // Decide routing by priority: hypervisor, monitor, kernel.
    always_comb begin
        route_hyp = hyp_en && (trap_all || trap_dbg);
        route_mon = mon_present && !mon_wide && is_secure;
        if (route_hyp)      tgt = LVL_HYP;
        else if (route_mon) tgt = LVL_MON;
        else                tgt = LVL_KERN;
    end
endmodule

// File: rtl/dbg_enable_eval.sv
// Evaluates whether debug exceptions may be generated at the current level.
// Lock status overrides all; level 3 never generates; secure disable applies
// below level 3; same-level needs the kernel enable with the mask clear;
// otherwise the target must be above the current level. Combinational.
module dbg_enable_eval
    import dbg_route_pkg::*;
(
    input  lvl_t cur,
    input  lvl_t tgt,
    input  logic is_secure,
    input  logic sec_dbg_off,
    input  logic kern_dbg_en,
    input  logic dbg_mask,
    input  logic os_lock,
    input  logic dbl_lock,
    output logic en
);
    // Walk the checks in priority order.
    always_comb begin
        if (os_lock || dbl_lock)
            en = 1'b0;
        else if (cur == LVL_MON)
            en = 1'b0;
        else if (is_secure && sec_dbg_off)
            en = 1'b0;
        else if (cur == tgt)
            en = kern_dbg_en && !dbg_mask;
        else
            en = (tgt > cur);
    end
endmodule

// File: rtl/dbg_gate_route.sv
// Top of the debug gate/route block: combines target selection and enable
// evaluation, derives the syndrome flag, breakpoint level and single-step
// state, and registers all outputs once. Synchronous active-low reset
// clears every output. Assumes one result per clock, one cycle of latency.
module dbg_gate_route
    import dbg_route_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   cur_lvl,
    input  logic               is_secure,
    input  logic               hyp_en,
    input  logic               trap_all,
    input  logic               trap_dbg,
    input  logic               mon_present,
    input  logic [NUM_LVL-1:0] lvl_wide,
    input  logic               sec_dbg_off,
    input  logic               kern_dbg_en,
    input  logic               dbg_mask,
    input  logic               os_lock,
    input  logic               dbl_lock,
    input  logic               step_bit,
    output logic               dbg_en,
    output logic [LVL_W-1:0]   tgt_lvl,
    output logic               same_lvl,
    output logic [LVL_W-1:0]   brk_lvl,
    output logic               step_act
);
    lvl_t tgt_c;
    lvl_t brk_c;
    logic en_c;
    logic same_c;
    logic step_c;

    dbg_target_sel u_tsel (
        .hyp_en      (hyp_en),
        .trap_all    (trap_all),
        .trap_dbg    (trap_dbg),
        .mon_present (mon_present),
        .mon_wide    (lvl_wide[LVL_MON]),
        .is_secure   (is_secure),
        .tgt         (tgt_c)
    );

    dbg_enable_eval u_eval (
        .cur         (cur_lvl),
        .tgt         (tgt_c),
        .is_secure   (is_secure),
        .sec_dbg_off (sec_dbg_off),
        .kern_dbg_en (kern_dbg_en),
        .dbg_mask    (dbg_mask),
        .os_lock     (os_lock),
        .dbl_lock    (dbl_lock),
        .en          (en_c)
    );

    // Derive syndrome flag, breakpoint level and single-step state.
    always_comb begin
        same_c = (tgt_c == cur_lvl);
        brk_c  = (tgt_c < cur_lvl) ? cur_lvl : tgt_c;
        step_c = step_bit && lvl_wide[tgt_c] && en_c;
    end

    // Register all outputs; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbg_en   <= 1'b0;
            tgt_lvl  <= '0;
            same_lvl <= 1'b0;
            brk_lvl  <= '0;
            step_act <= 1'b0;
        end else begin
            dbg_en   <= en_c;
            tgt_lvl  <= tgt_c;
            same_lvl <= same_c;
            brk_lvl  <= brk_c;
            step_act <= step_c;
        end
    end

    // R3
    never_top_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cur_lvl) == LVL_MON) |-> !dbg_en);
    // R7
    lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(os_lock) || $past(dbl_lock))) |-> !dbg_en);
    // R9
    brk_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (brk_lvl >= $past(cur_lvl)));
    // R10
    step_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_act |-> dbg_en);
    // R8
    same_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (same_lvl == (tgt_lvl == $past(cur_lvl))));
    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!dbg_en && !step_act));
endmodule

// File: tb/dbg_gate_route_bench.sv
module dbg_gate_route_bench;
    typedef struct packed {
        logic [1:0] cur;
        logic sec, hyp, tge, tde, mp;
        logic [3:0] wide;
        logic sdd, kde, msk, osl, dbl, stp;
    } vec_t;

    typedef struct {
        logic       en;
        logic [1:0] tgt;
        logic       same;
        logic [1:0] brk;
        logic       step;
        string      tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    vec_t v = '0;
    logic dbg_en, same_lvl, step_act;
    logic [1:0] tgt_lvl, brk_lvl;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    dbg_gate_route u_dbg_gate_route (
        .clk(clk), .rst_n(rst_n), .cur_lvl(v.cur), .is_secure(v.sec),
        .hyp_en(v.hyp), .trap_all(v.tge), .trap_dbg(v.tde),
        .mon_present(v.mp), .lvl_wide(v.wide), .sec_dbg_off(v.sdd),
        .kern_dbg_en(v.kde), .dbg_mask(v.msk), .os_lock(v.osl),
        .dbl_lock(v.dbl), .step_bit(v.stp), .dbg_en(dbg_en),
        .tgt_lvl(tgt_lvl), .same_lvl(same_lvl), .brk_lvl(brk_lvl),
        .step_act(step_act)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(vec_t x, string tag);
        exp_t e;
        int t, c;
        c = int'(x.cur);
        if (x.hyp && (x.tge || x.tde)) t = 2;          // R1
        else if (x.mp && !x.wide[3] && x.sec) t = 3;   // R2
        else t = 1;
        e.tgt = 2'(t);
        e.same = (t == c);                             // R8
        e.brk = 2'((t < c) ? c : t);                   // R9
        if (x.osl || x.dbl) e.en = 0;                  // R7
        else if (c == 3) e.en = 0;                     // R3
        else if (x.sec && x.sdd) e.en = 0;             // R4
        else if (t == c) e.en = x.kde && !x.msk;       // R5
        else e.en = (t > c);                           // R6
        e.step = x.stp && x.wide[t] && e.en;           // R10
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(vec_t x, string tag);
        @(negedge clk);
        v = x;
        sb.push_back(model(x, tag));
    endtask

    task automatic cmp(string req, string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", req, tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per clock, one cycle after its drive.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp("R1 R2 target", e.tag, int'(tgt_lvl), int'(e.tgt));
            cmp("R3 R4 R5 R6 R7 enable", e.tag, int'(dbg_en), int'(e.en));
            cmp("R8 same-level", e.tag, int'(same_lvl), int'(e.same));
            cmp("R9 breakpoint", e.tag, int'(brk_lvl), int'(e.brk));
            cmp("R10 step", e.tag, int'(step_act), int'(e.step));
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t x;
        // R11: reset state with busy inputs
        v = '{cur:2'd1, sec:0, hyp:0, tge:0, tde:0, mp:0, wide:4'hF,
              sdd:0, kde:1, msk:0, osl:0, dbl:0, stp:1};
        repeat (3) @(posedge clk);
        #1;
        cmp("R11 reset", "reset", int'({dbg_en, tgt_lvl, same_lvl, brk_lvl, step_act}), 0);
        @(negedge clk);
        rst_n = 1;

        // R5 R10: level 1, kernel target, enable set, mask clear
        drive(v, "R5 same level enabled");
        x = v; x.msk = 1; drive(x, "R5 mask blocks");
        x = v; x.kde = 0; drive(x, "R5 kernel enable clear");
        x = v; x.wide = 4'hD; drive(x, "R10 target level narrow");
        // R6: level 0 with kernel target, higher target enables
        x = v; x.cur = 0; x.kde = 0; drive(x, "R6 target above");
        // R9 R6: level 2, target 1 below
        x = v; x.cur = 2; drive(x, "R9 lift breakpoint level");
        // R1: hypervisor routing
        x = v; x.cur = 1; x.hyp = 1; x.tge = 1; drive(x, "R1 trap general");
        x = v; x.cur = 2; x.hyp = 1; x.tde = 1; drive(x, "R1 trap debug same level");
        x = v; x.hyp = 0; x.tde = 1; drive(x, "R1 hyp off no route");
        // R2: secure 32-bit monitor
        x = v; x.cur = 0; x.sec = 1; x.mp = 1; x.wide = 4'h7; drive(x, "R2 monitor target");
        x = v; x.cur = 0; x.sec = 1; x.mp = 1; x.wide = 4'hF; drive(x, "R2 wide monitor");
        // R3: level 3 same-level with enable set
        x = v; x.cur = 3; x.sec = 1; x.mp = 1; x.wide = 4'h7; drive(x, "R3 level 3 blocked");
        // R4: secure disable
        x = v; x.cur = 0; x.sec = 1; x.sdd = 1; drive(x, "R4 secure disable");
        x = v; x.cur = 0; x.sec = 0; x.sdd = 1; drive(x, "R4 nonsecure unaffected");
        // R7: locks
        x = v; x.cur = 0; x.osl = 1; drive(x, "R7 os lock");
        x = v; x.cur = 0; x.dbl = 1; drive(x, "R7 double lock");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            x = vec_t'($urandom);
            drive(x, "random");
        end
        // R11: reset mid-run clears outputs
        @(negedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        cmp("R11 reset mid-run", "reset", int'({dbg_en, tgt_lvl, same_lvl, brk_lvl, step_act}), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule